// File: doc/BRIEF.md
# Interleaved Single-Correct Double-Detect Memory Word Codec

This block protects a memory row made of eight logical words. Each logical word holds 128 data bits and is stored as a 137-bit codeword: a Hamming code with its check bits at the power-of-two positions, plus one overall parity bit. The encoder side takes the eight data words and produces the full physical row. The decoder side takes a physical row read back from the array and returns the eight data words, repaired where possible. Each word also has a flag that says a single error was repaired and a flag that says the word is beyond repair.

The physical row is woven bit by bit. Physical bit `p` belongs to logical word `p % 8` and sits at codeword position `p / 8`. A defect that spoils up to eight neighbouring cells therefore lands at most once in any one codeword, and each codeword can repair it on its own.

The encoder is purely combinational. A parameter selects whether the decoder results leave through a register stage that has a synchronous active-high reset, or straight from the logic.

Top module: `sdc_codec`

## Requirements
- R1: Each logical word is a 137-bit codeword. Bit 0 is the overall parity bit. Bits 1 to 136 are Hamming positions, with the check bits at positions 1, 2, 4, 8, 16, 32, 64 and 128. Data bit j sits at the j-th position, in ascending order, that is not a power of two (data bit 0 at position 3, data bit 127 at position 136).
- R2: Every encoded codeword has even parity over all 137 bits. The XOR of the indices of its set bits among positions 1 to 136 (its syndrome) is zero.
- R3: In a row, physical bit p carries codeword position p / 8 of logical word p % 8. Data word w occupies `wr_data[w*128 +: 128]`, and bit w of each flag vector belongs to word w.
- R4: A row read back unchanged returns every data word intact, with both flags clear for all words.
- R5: A single flipped bit at any codeword position from 1 to 136 is repaired. The returned data is the original, and only that word's repaired flag is set.
- R6: A flipped overall parity bit (position 0) sets that word's repaired flag and leaves its data intact.
- R7: Two flipped bits in one codeword set that word's fatal flag and leave its repaired flag clear.
- R8: An odd number of flips whose syndrome exceeds 136 is reported as fatal, not repaired.
- R9: No word ever has both its repaired flag and its fatal flag set.
- R10: With OUT_REG=1, decoder results appear on the clock edge after the row is presented, and reset clears them to zero. With OUT_REG=0 they follow the row combinationally.
- R11: A burst of up to eight adjacent physical bits is repaired in full, with one repaired flag for each affected word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rst | input | 1 | Synchronous active-high reset |
| wr_data | input | 1024 | Eight data words to encode |
| wr_row | output | 1096 | Encoded, interleaved physical row |
| rd_row | input | 1096 | Physical row read back from the array |
| rd_data | output | 1024 | Eight decoded, repaired data words |
| rd_fixed | output | 8 | Per-word flag: a single error was repaired |
| rd_fatal | output | 8 | Per-word flag: an uncorrectable error was found |

## Verification
A fault in the weaving map or the data placement shows at the ports on the very read that follows. Either a one-bit flip is blamed on the wrong word's flag, or a lone data bit encodes to check bits at the wrong positions. A wrong syndrome or parity path either raises the wrong flag or leaves a flipped bit in the data, one clock after the row is presented with the output stage, or at once without it. Out-of-range syndromes and bursts across neighbouring cells are stimulated on purpose, because a decoder that only mishandles those would pass every plain single-flip read.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

    // Outcome of decoding one codeword
    typedef enum logic [1:0] {
        DS_CLEAN = 2'd0,
        DS_FIXED = 2'd1,
        DS_FATAL = 2'd2
    } dec_status_e;

    typedef struct packed {
        logic fixed;
        logic fatal;
    } dec_flags_t;

    // Smallest number of Hamming check bits r with 2^r >= dw + r + 1
    function automatic int ham_bits(input int dw);
        for (int r = 1; r < 31; r++) begin
            if ((1 << r) >= dw + r + 1) return r;
        end
        return 31;
    endfunction

    function automatic bit is_pow2(input int v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction

    // Codeword position of data bit j: the j-th non-power-of-two position >= 3
    function automatic int data_pos(input int j);
        int seen;
        seen = 0;
        for (int p = 3; p < 4096; p++) begin
            if (!is_pow2(p)) begin
                if (seen == j) return p;
                seen++;
            end
        end
        return 0;
    endfunction

    function automatic dec_flags_t status_to_flags(input dec_status_e st);
        dec_flags_t f;
        f.fixed = (st == DS_FIXED);
        f.fatal = (st == DS_FATAL);
        return f;
    endfunction

endpackage

// File: rtl/sdc_enc.sv
module sdc_enc
    import sdc_pkg::*;
#(
    parameter int DW = 128
) (
    input  logic [DW-1:0]                 data,
    output logic [DW+ham_bits(DW):0]      word
);
    localparam int HW   = ham_bits(DW);
    localparam int CW   = DW + HW + 1;
    localparam int MAXP = DW + HW;
    localparam int IW   = $clog2(CW);

    logic [CW-1:0] cw_q;
    logic          par;

    always_comb begin
        cw_q = '0;
        // scatter data into non-power-of-two positions
        for (int j = 0; j < DW; j++) begin
            cw_q[IW'(data_pos(j))] = data[j];
        end
        // each check bit covers positions whose index has that bit set
        for (int k = 0; k < HW; k++) begin
            par = 1'b0;
            for (int p = 1; p <= MAXP; p++) begin
                if (((p >> k) & 1) == 1) par = par ^ cw_q[IW'(p)];
            end
            cw_q[IW'(1 << k)] = par;
        end
        // overall parity makes the whole word even
        cw_q[0] = ^cw_q[CW-1:1];
    end

    assign word = cw_q;

endmodule

// File: rtl/sdc_dec.sv
module sdc_dec
    import sdc_pkg::*;
#(
    parameter int DW = 128
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [DW+ham_bits(DW):0]      word,
    output logic [DW-1:0]                 data,
    output logic                          fixed,
    output logic                          fatal
);
    localparam int HW   = ham_bits(DW);
    localparam int CW   = DW + HW + 1;
    localparam int MAXP = DW + HW;
    localparam int IW   = $clog2(CW);

    logic [HW-1:0] syn;
    logic          par_bad;
    logic [CW-1:0] mended;
    logic [DW-1:0] raw;
    dec_status_e   st;
    dec_flags_t    fl;

    // syndrome: XOR of the indices of all set Hamming positions
    always_comb begin
        syn = '0;
        for (int p = 1; p <= MAXP; p++) begin
            if (word[IW'(p)]) syn = syn ^ HW'(p);
        end
        par_bad = ^word;
    end

    // classify and build the repaired word
    always_comb begin
        mended = word;
        st     = DS_CLEAN;
        if (syn == '0) begin
            if (par_bad) st = DS_FIXED;           // only the overall bit flipped
        end else if (!par_bad) begin
            st = DS_FATAL;                        // even count: double error
        end else if (int'(syn) > MAXP) begin
            st = DS_FATAL;                        // names a position that does not exist
        end else begin
            st = DS_FIXED;
            for (int p = 1; p <= MAXP; p++) begin
                if (HW'(p) == syn) mended[IW'(p)] = ~word[IW'(p)];
            end
        end
    end

    always_comb begin
        for (int j = 0; j < DW; j++) begin
            data[j] = mended[IW'(data_pos(j))];
            raw[j]  = word[IW'(data_pos(j))];
        end
    end

    assign fl    = status_to_flags(st);
    assign fixed = fl.fixed;
    assign fatal = fl.fatal;

    // R9: a word is never both repaired and fatal
    a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({fixed, fatal}));

    // R5: a repair changes at most one data bit
    a_r5_single_bit_repair: assert property (@(posedge clk) disable iff (rst)
        $countones(data ^ raw) <= 1);

    // R4: without a repair, data leaves exactly as it was stored
    a_r4_no_repair_no_change: assert property (@(posedge clk) disable iff (rst)
        !fixed |-> (data == raw));

endmodule

// File: rtl/sdc_codec.sv
module sdc_codec
    import sdc_pkg::*;
#(
    parameter int DW      = 128,
    parameter int WAYS    = 8,
    parameter bit OUT_REG = 1'b1
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic [WAYS*DW-1:0]                  wr_data,
    output logic [WAYS*(DW+ham_bits(DW)+1)-1:0] wr_row,
    input  logic [WAYS*(DW+ham_bits(DW)+1)-1:0] rd_row,
    output logic [WAYS*DW-1:0]                  rd_data,
    output logic [WAYS-1:0]                     rd_fixed,
    output logic [WAYS-1:0]                     rd_fatal
);
    localparam int HW = ham_bits(DW);
    localparam int CW = DW + HW + 1;

    logic [WAYS*DW-1:0] comb_data;
    logic [WAYS-1:0]    comb_fixed;
    logic [WAYS-1:0]    comb_fatal;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [CW-1:0] enc_word;
        logic [CW-1:0] rd_word;
        logic [DW-1:0] dec_data;
        logic          fx;
        logic          ft;

        sdc_enc #(.DW(DW)) u_enc (
            .data (wr_data[w*DW +: DW]),
            .word (enc_word)
        );

        // bit-by-bit weave: neighbours in the row belong to different words
        for (genvar b = 0; b < CW; b++) begin : g_bit
            assign wr_row[b*WAYS + w] = enc_word[b];
            assign rd_word[b]         = rd_row[b*WAYS + w];
        end

        sdc_dec #(.DW(DW)) u_dec (
            .clk   (clk),
            .rst   (rst),
            .word  (rd_word),
            .data  (dec_data),
            .fixed (fx),
            .fatal (ft)
        );

        assign comb_data[w*DW +: DW] = dec_data;
        assign comb_fixed[w]         = fx;
        assign comb_fatal[w]         = ft;
    end

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                rd_data  <= '0;
                rd_fixed <= '0;
                rd_fatal <= '0;
            end else begin
                rd_data  <= comb_data;
                rd_fixed <= comb_fixed;
                rd_fatal <= comb_fatal;
            end
        end

        // R10: the first cycle out of reset still shows cleared results
        a_r10_reset_clears: assert property (@(posedge clk) disable iff (rst)
            $fell(rst) |-> (rd_data == '0 && rd_fixed == '0 && rd_fatal == '0));

        // R4: a row read back unchanged returns what was written, a cycle later
        a_r4_loopback: assert property (@(posedge clk) disable iff (rst)
            (rd_row == wr_row) |=>
                (rd_data == $past(wr_data) && rd_fixed == '0 && rd_fatal == '0));
    end else begin : g_comb
        assign rd_data  = comb_data;
        assign rd_fixed = comb_fixed;
        assign rd_fatal = comb_fatal;

        // R4: combinational loopback through encoder and decoder
        a_r4_loopback: assert property (@(posedge clk) disable iff (rst)
            (rd_row == wr_row) |->
                (rd_data == wr_data && rd_fixed == '0 && rd_fatal == '0));
    end

endmodule

// File: tb/sim_sdc_codec.sv
module sim_sdc_codec;
    localparam int DW   = 128;
    localparam int WAYS = 8;
    localparam int CW   = 137;
    localparam int RW   = WAYS * CW;
    localparam int TW   = WAYS * DW;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [TW-1:0]   wr_data = '0;
    logic [RW-1:0]   wr_row;
    logic [RW-1:0]   rd_row = '0;
    logic [TW-1:0]   rd_data;
    logic [WAYS-1:0] rd_fixed;
    logic [WAYS-1:0] rd_fatal;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;   // 50 MHz

    sdc_codec u0 (
        .clk      (clk),
        .rst      (rst),
        .wr_data  (wr_data),
        .wr_row   (wr_row),
        .rd_row   (rd_row),
        .rd_data  (rd_data),
        .rd_fixed (rd_fixed),
        .rd_fatal (rd_fatal)
    );

    function automatic int phys(input int w, input int b);
        return b * WAYS + w;
    endfunction

    function automatic logic [TW-1:0] rnd_data();
        logic [TW-1:0] d;
        for (int i = 0; i < TW / 32; i++) d[i*32 +: 32] = $urandom;
        return d;
    endfunction

    task automatic chk(input bit ok, input string tag,
                       input logic [RW-1:0] act, input logic [RW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic encode(input logic [TW-1:0] d, output logic [RW-1:0] row);
        @(negedge clk);
        wr_data = d;
        #1;
        row = wr_row;
    endtask

    task automatic decode(input logic [RW-1:0] row);
        @(negedge clk);
        rd_row = row;
        @(posedge clk);
        @(negedge clk);
    endtask

    // compare flags, and data of every word not expected to be fatal
    task automatic check_dec(input string tag, input logic [TW-1:0] exp_d,
                             input logic [WAYS-1:0] exp_fx, input logic [WAYS-1:0] exp_ft);
        for (int w = 0; w < WAYS; w++) begin
            if (!exp_ft[w])
                chk(rd_data[w*DW +: DW] == exp_d[w*DW +: DW], {tag, " data"},
                    RW'(rd_data[w*DW +: DW]), RW'(exp_d[w*DW +: DW]));
        end
        chk(rd_fixed == exp_fx, {tag, " fixed"}, RW'(rd_fixed), RW'(exp_fx));
        chk(rd_fatal == exp_ft, {tag, " fatal"}, RW'(rd_fatal), RW'(exp_ft));
        chk((rd_fixed & rd_fatal) == '0, "R9 flags exclusive",
            RW'(rd_fixed & rd_fatal), RW'(0));
    endtask

    task automatic t_reset();
        // R10: garbage on the row during reset must not reach the outputs
        @(negedge clk);
        rd_row = '1;
        @(posedge clk);
        @(negedge clk);
        chk(rd_data == '0, "R10 reset data", RW'(rd_data), RW'(0));
        chk(rd_fixed == '0 && rd_fatal == '0, "R10 reset flags",
            RW'({rd_fixed, rd_fatal}), RW'(0));
        rd_row = '0;
        rst = 1'b0;
    endtask

    task automatic t_encode();
        logic [RW-1:0] row;
        logic [RW-1:0] exp;
        logic [TW-1:0] d;
        // R2: every word even and with zero syndrome
        for (int k = 0; k < 3; k++) begin
            d = (k == 0) ? '1 : rnd_data();
            encode(d, row);
            for (int w = 0; w < WAYS; w++) begin
                logic par;
                int   syn;
                par = 1'b0;
                syn = 0;
                for (int b = 0; b < CW; b++) begin
                    par = par ^ row[phys(w, b)];
                    if (b > 0 && row[phys(w, b)]) syn = syn ^ b;
                end
                chk(par == 1'b0, "R2 even parity", RW'(par), RW'(0));
                chk(syn == 0, "R2 zero syndrome", RW'(syn), RW'(0));
            end
        end
        // R1 R3: data bit 0 of word 3 -> positions 0,1,2,3 of word 3 only
        d = '0;
        d[3*DW] = 1'b1;
        encode(d, row);
        exp = '0;
        for (int b = 0; b < 4; b++) exp[phys(3, b)] = 1'b1;
        chk(row == exp, "R1 R3 data bit 0 placement", row, exp);
        // R1: data bit 127 of word 0 -> position 136, checks 8 and 128, parity 0
        d = '0;
        d[127] = 1'b1;
        encode(d, row);
        exp = '0;
        exp[phys(0, 136)] = 1'b1;
        exp[phys(0, 8)]   = 1'b1;
        exp[phys(0, 128)] = 1'b1;
        exp[phys(0, 0)]   = 1'b1;
        chk(row == exp, "R1 data bit 127 placement", row, exp);
    endtask

    task automatic t_clean();
        logic [RW-1:0] row;
        logic [TW-1:0] d;
        for (int k = 0; k < 4; k++) begin
            case (k)
                0:       d = '0;
                1:       d = '1;
                2:       d = {(TW/8){8'hA5}};
                default: d = rnd_data();
            endcase
            encode(d, row);
            decode(row);
            check_dec("R4 clean read", d, '0, '0);
        end
    endtask

    task automatic t_single();
        logic [RW-1:0] row;
        logic [TW-1:0] d;
        int            ws[6] = '{0, 1, 7, 3, 5, 2};
        int            bs[6] = '{1, 13, 136, 69, 64, 128};
        d = rnd_data();
        encode(d, row);
        for (int i = 0; i < 6; i++) begin
            logic [RW-1:0] bad;
            bad = row;
            bad[phys(ws[i], bs[i])] = ~bad[phys(ws[i], bs[i])];
            decode(bad);
            check_dec("R5 R3 single flip", d, WAYS'(1 << ws[i]), '0);
        end
    endtask

    task automatic t_parity_bit();
        logic [RW-1:0] row;
        logic [TW-1:0] d;
        d = rnd_data();
        encode(d, row);
        for (int w = 0; w < WAYS; w += 5) begin
            logic [RW-1:0] bad;
            bad = row;
            bad[phys(w, 0)] = ~bad[phys(w, 0)];
            decode(bad);
            check_dec("R6 parity bit flip", d, WAYS'(1 << w), '0);
        end
    endtask

    task automatic t_double();
        logic [RW-1:0] row;
        logic [RW-1:0] bad;
        logic [TW-1:0] d;
        d = rnd_data();
        encode(d, row);
        bad = row;
        bad[phys(2, 5)] = ~bad[phys(2, 5)];
        bad[phys(2, 9)] = ~bad[phys(2, 9)];
        decode(bad);
        check_dec("R7 double flip", d, '0, 8'h04);
        bad = row;
        bad[phys(6, 1)]   = ~bad[phys(6, 1)];
        bad[phys(6, 136)] = ~bad[phys(6, 136)];
        decode(bad);
        check_dec("R7 double flip wide", d, '0, 8'h40);
    endtask

    task automatic t_beyond();
        logic [RW-1:0] row;
        logic [RW-1:0] bad;
        logic [TW-1:0] d;
        // positions 1, 8, 128 -> syndrome 137, odd count
        d = rnd_data();
        encode(d, row);
        bad = row;
        bad[phys(4, 1)]   = ~bad[phys(4, 1)];
        bad[phys(4, 8)]   = ~bad[phys(4, 8)];
        bad[phys(4, 128)] = ~bad[phys(4, 128)];
        decode(bad);
        check_dec("R8 syndrome beyond 136", d, '0, 8'h10);
    endtask

    task automatic t_burst();
        logic [RW-1:0] row;
        logic [RW-1:0] bad;
        logic [TW-1:0] d;
        d = rnd_data();
        encode(d, row);
        bad = row;
        for (int p = 800; p < 808; p++) bad[p] = ~bad[p];
        decode(bad);
        check_dec("R11 eight-cell burst", d, 8'hFF, '0);
        bad = row;
        for (int p = 803; p < 806; p++) bad[p] = ~bad[p];
        decode(bad);
        check_dec("R11 three-cell burst", d, 8'h38, '0);
    endtask

    task automatic t_latency();
        logic [RW-1:0] row;
        logic [RW-1:0] bad;
        logic [TW-1:0] d;
        d = rnd_data();
        encode(d, row);
        decode(row);
        bad = row;
        bad[phys(1, 40)] = ~bad[phys(1, 40)];
        @(negedge clk);
        rd_row = bad;
        #5;
        chk(rd_fixed == '0, "R10 result held before edge", RW'(rd_fixed), RW'(0));
        @(posedge clk);
        #1;
        chk(rd_fixed == 8'h02, "R10 result after one edge", RW'(rd_fixed), RW'(8'h02));
        chk(rd_data == d, "R10 data after one edge", RW'(rd_data), RW'(d));
    endtask

    initial begin
        t_reset();
        t_encode();
        t_clean();
        t_single();
        t_parity_bit();
        t_double();
        t_beyond();
        t_burst();
        t_latency();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule